// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block steps through a ring of transmit descriptors held in a small internal table. Host software fills the table through a one-entry-per-cycle write port. Each entry holds a buffer address, a byte length and four flags: ready, wrap, end-of-frame and interrupt-request. While running, the walker offers the entry under its pointer downstream as a fetch request on a valid/ready handshake. The request carries the address, the length, and markers for the first and final pieces of a frame. When a request is accepted, the walker clears that entry's ready flag, which hands the entry back to software. It then advances to the next index. After an entry with the wrap flag set, it returns to the programmed base index instead.

The walker halts when it meets an entry that is not ready. It waits in that state until software writes a one to this queue's halt-clear bit, and then resumes at the same entry. A graceful-stop input lets the frame in flight finish. The walker then stops before starting another frame and reports that it has stopped. When the accepted entry ends a frame and requests an interrupt, a one-cycle completion pulse follows.

Top module: `txd_ring_walker`

## Requirements
- R1: After reset the walker is halted. `req_valid`, `stopped` and `frame_done` are low, every entry reads back not ready, and the first entry offered after the first restart is the one at `base_idx`.
- R2: The walker leaves the halted state only on a cycle with `hclr_we` high and `hclr_data` bit `HCW-1-QIDX` set. With the defaults this is bit 7, the queue-0 bit, and queue n uses the bit n places lower. A write with only other bits set leaves `halted` at 1.
- R3: While running, if the entry under the pointer is ready, `req_valid` is high and shows that entry's address, length and end-of-frame flag. `req_first` is 1 when no frame is open, and 0 after an accepted entry whose end-of-frame flag was 0.
- R4: While `req_valid` is high and `req_ready` is low, the request and all its fields hold unchanged into the next cycle.
- R5: On the clock edge where a request is accepted, the ready flag of that entry becomes 0, as seen on `rd_ready`.
- R6: After an accepted entry, the next entry is the following index (modulo `DEPTH`). If the accepted entry had its wrap flag set, the next entry is `base_idx` instead.
- R7: When the running walker finds the entry under the pointer not ready, it goes halted with `req_valid` low. After the restart it offers that same entry.
- R8: `frame_done` pulses for one cycle, one cycle after the acceptance of an entry that has both its end-of-frame and interrupt flags set. It never pulses otherwise.
- R9: With `gstop` high, the walker keeps serving the open frame. When no frame is open and no request is outstanding, it raises `stopped` and offers nothing. When `gstop` falls, it runs again from where it stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_we | input | 1 | Descriptor table write strobe |
| sw_idx | input | IW | Entry index written |
| sw_ready | input | 1 | Ready flag written |
| sw_wrap | input | 1 | Wrap flag written |
| sw_last | input | 1 | End-of-frame flag written |
| sw_irq | input | 1 | Interrupt-request flag written |
| sw_len | input | LW | Length written |
| sw_addr | input | AW | Buffer address written |
| rd_idx | input | IW | Entry whose ready flag is read back |
| rd_ready | output | 1 | Ready flag of entry `rd_idx` |
| base_idx | input | IW | Ring start index |
| hclr_we | input | 1 | Halt-clear write strobe |
| hclr_data | input | HCW | Halt-clear data, one bit per queue |
| gstop | input | 1 | Graceful stop request |
| req_valid | output | 1 | Fetch request valid |
| req_ready | input | 1 | Fetch request accepted downstream |
| req_addr | output | AW | Buffer address of the request |
| req_len | output | LW | Length of the request |
| req_first | output | 1 | Request opens a frame |
| req_last | output | 1 | Request closes a frame |
| halted | output | 1 | Halt status |
| stopped | output | 1 | Graceful stop reached |
| frame_done | output | 1 | Frame completion pulse |

## Verification
The bench goes after the hold of an unaccepted request. A walker that reacts to `gstop` while a request is still waiting would withdraw `req_valid` or switch its fields mid-handshake. It also checks that `gstop` raised in the middle of a multi-entry frame lets that frame finish; a walker that checked `gstop` on every entry would stop between the pieces of a frame. Wrap handling is checked by the address offered after a wrap entry: a design that ignored the wrap flag would offer the next index instead of the base. A halt on a not-ready entry must resume at that same entry; a design that stepped past it would skip a descriptor. Completion pulses are checked for frames whose final entry has the interrupt flag clear, where a careless design would still pulse.

// File: rtl/txd_ring_walker.sv
module txd_ring_walker #(
  parameter int DEPTH = 16,
  parameter int AW    = 32,
  parameter int LW    = 16,
  parameter int HCW   = 8,
  parameter int QIDX  = 0,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_we,
  input  logic [IW-1:0] sw_idx,
  input  logic          sw_ready,
  input  logic          sw_wrap,
  input  logic          sw_last,
  input  logic          sw_irq,
  input  logic [LW-1:0] sw_len,
  input  logic [AW-1:0] sw_addr,
  input  logic [IW-1:0] rd_idx,
  output logic          rd_ready,
  input  logic [IW-1:0] base_idx,
  input  logic          hclr_we,
  input  logic [HCW-1:0] hclr_data,
  input  logic          gstop,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  output logic [LW-1:0] req_len,
  output logic          req_first,
  output logic          req_last,
  output logic          halted,
  output logic          stopped,
  output logic          frame_done
);

  localparam int HBIT = HCW - 1 - QIDX;

  typedef enum logic [1:0] {S_HALT, S_RUN, S_STOP} st_t;

  st_t           st;
  logic [IW-1:0] ptr;
  logic [IW-1:0] cur;
  logic          rewind;
  logic          in_frame;
  logic          lock;

  logic [DEPTH-1:0] d_rdy, d_wrp, d_lst, d_irq;
  logic [LW-1:0]    d_len [DEPTH];
  logic [AW-1:0]    d_adr [DEPTH];

  wire unused_hclr = ^hclr_data;

  assign cur = rewind ? base_idx : ptr;

  wire gate = gstop && !in_frame && !lock;
  wire kick = hclr_we && hclr_data[HBIT];

  assign req_valid = (st == S_RUN) && d_rdy[cur] && !gate;
  assign req_addr  = d_adr[cur];
  assign req_len   = d_len[cur];
  assign req_last  = d_lst[cur];
  assign req_first = !in_frame;
  assign halted    = (st == S_HALT);
  assign stopped   = (st == S_STOP);
  assign rd_ready  = d_rdy[rd_idx];

  wire take = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_HALT;
      ptr        <= '0;
      rewind     <= 1'b1;
      in_frame   <= 1'b0;
      lock       <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      frame_done <= take && d_lst[cur] && d_irq[cur];
      case (st)
        S_HALT: if (kick) st <= S_RUN;
        S_RUN: begin
          if (take) begin
            in_frame <= !d_lst[cur];
            lock     <= 1'b0;
            if (d_wrp[cur]) begin
              rewind <= 1'b1;
            end else begin
              rewind <= 1'b0;
              ptr    <= cur + 1'b1;
            end
          end else if (req_valid) begin
            lock <= 1'b1;
          end else if (gate) begin
            st <= S_STOP;
          end else begin
            st <= S_HALT;
          end
        end
        S_STOP: if (!gstop) st <= S_RUN;
        default: st <= S_HALT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_rdy <= '0;
      d_wrp <= '0;
      d_lst <= '0;
      d_irq <= '0;
    end else begin
      if (take) d_rdy[cur] <= 1'b0;
      if (sw_we) begin
        d_rdy[sw_idx] <= sw_ready;
        d_wrp[sw_idx] <= sw_wrap;
        d_lst[sw_idx] <= sw_last;
        d_irq[sw_idx] <= sw_irq;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (sw_we) begin
      d_len[sw_idx] <= sw_len;
      d_adr[sw_idx] <= sw_addr;
    end
  end

endmodule

// File: rtl/txd_ring_walker_chk.sv
module txd_ring_walker_chk #(
  parameter int AW   = 32,
  parameter int LW   = 16,
  parameter int HCW  = 8,
  parameter int QIDX = 0
) (
  input logic           clk,
  input logic           rst_n,
  input logic           hclr_we,
  input logic [HCW-1:0] hclr_data,
  input logic           gstop,
  input logic           req_valid,
  input logic           req_ready,
  input logic [AW-1:0]  req_addr,
  input logic [LW-1:0]  req_len,
  input logic           req_first,
  input logic           req_last,
  input logic           halted,
  input logic           stopped,
  input logic           frame_done
);
  localparam int HBIT = HCW - 1 - QIDX;
  wire unused_hclr = ^hclr_data;

  AST_LEAVE_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halted) |-> $past(hclr_we && hclr_data[HBIT])); // R2

  AST_ONE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({halted, stopped, req_valid})); // R3

  AST_HOLD_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_len)
                                   && $stable(req_last) && $stable(req_first))); // R4

  AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !req_valid); // R7

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> $past(req_valid && req_ready && req_last)); // R8

  AST_STOP_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stopped) |-> $past(gstop)); // R9
endmodule

bind txd_ring_walker txd_ring_walker_chk #(.AW(AW), .LW(LW), .HCW(HCW), .QIDX(QIDX)) u_chk (
  .clk(clk), .rst_n(rst_n), .hclr_we(hclr_we), .hclr_data(hclr_data), .gstop(gstop),
  .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
  .req_first(req_first), .req_last(req_last), .halted(halted), .stopped(stopped),
  .frame_done(frame_done)
);

// File: tb/txd_ring_walker_test.sv
`timescale 1ns/1ps
module txd_ring_walker_test;
  localparam int D = 16;

  logic clk = 0, rst_n = 0;
  logic sw_we = 0, sw_ready = 0, sw_wrap = 0, sw_last = 0, sw_irq = 0;
  logic [3:0] sw_idx = 0, rd_idx = 0, base_idx = 4'd2;
  logic [15:0] sw_len = 0;
  logic [31:0] sw_addr = 0;
  logic rd_ready;
  logic hclr_we = 0;
  logic [7:0] hclr_data = 0;
  logic gstop = 0, req_ready = 0;
  logic req_valid, req_first, req_last, halted, stopped, frame_done;
  logic [31:0] req_addr;
  logic [15:0] req_len;

  int nchk = 0, nfail = 0;

  always #5 clk = ~clk;

  txd_ring_walker uut (
    .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_idx(sw_idx), .sw_ready(sw_ready),
    .sw_wrap(sw_wrap), .sw_last(sw_last), .sw_irq(sw_irq), .sw_len(sw_len), .sw_addr(sw_addr),
    .rd_idx(rd_idx), .rd_ready(rd_ready), .base_idx(base_idx), .hclr_we(hclr_we),
    .hclr_data(hclr_data), .gstop(gstop), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .req_first(req_first), .req_last(req_last),
    .halted(halted), .stopped(stopped), .frame_done(frame_done)
  );

  // behavioural reference
  int m_mode = 0, m_ptr = 0;
  bit m_rew = 1, m_inf = 0, m_lock = 0, m_done = 0;
  bit b_rdy[D], b_wrp[D], b_lst[D], b_irq[D];
  logic [15:0] b_len[D];
  logic [31:0] b_adr[D];

  function automatic int mcur();
    return m_rew ? int'(base_idx) : m_ptr;
  endfunction
  function automatic bit mgate();
    return gstop && !m_inf && !m_lock;
  endfunction
  function automatic bit mvalid();
    return (m_mode == 1) && b_rdy[mcur()] && !mgate();
  endfunction

  always @(posedge clk) begin
    int c;
    bit v, hs;
    if (!rst_n) begin
      m_mode = 0; m_ptr = 0; m_rew = 1; m_inf = 0; m_lock = 0; m_done = 0;
      for (int i = 0; i < D; i++) begin b_rdy[i] = 0; b_wrp[i] = 0; b_lst[i] = 0; b_irq[i] = 0; end
    end else begin
      c = mcur();
      v = mvalid();
      hs = v && req_ready;
      m_done = hs && b_lst[c] && b_irq[c];
      case (m_mode)
        0: if (hclr_we && hclr_data[7]) m_mode = 1;
        1: begin
          if (hs) begin
            m_inf = !b_lst[c];
            m_lock = 0;
            b_rdy[c] = 0;
            if (b_wrp[c]) m_rew = 1;
            else begin m_rew = 0; m_ptr = (c + 1) % D; end
          end else if (v) m_lock = 1;
          else if (mgate()) m_mode = 2;
          else m_mode = 0;
        end
        default: if (!gstop) m_mode = 1;
      endcase
      if (sw_we) begin
        b_rdy[sw_idx] = sw_ready; b_wrp[sw_idx] = sw_wrap; b_lst[sw_idx] = sw_last;
        b_irq[sw_idx] = sw_irq; b_len[sw_idx] = sw_len; b_adr[sw_idx] = sw_addr;
      end
    end
  end

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
    end
  endtask

  // per-clock comparison, away from the rising edge
  always begin
    @(negedge clk);
    #3;
    if (rst_n) begin
      chk("R7 halted", halted, m_mode == 0);
      chk("R9 stopped", stopped, m_mode == 2);
      chk("R3 req_valid", req_valid, mvalid());
      if (mvalid()) begin
        chk("R6 req_addr order", req_addr, b_adr[mcur()]);
        chk("R3 req_len", req_len, b_len[mcur()]);
        chk("R3 req_last", req_last, b_lst[mcur()]);
        chk("R3 req_first", req_first, !m_inf);
      end
      chk("R8 frame_done", frame_done, m_done);
      chk("R5 rd_ready", rd_ready, b_rdy[rd_idx]);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int idx, bit rdy, bit wrp, bit lst, bit irq, int len, logic [31:0] adr);
    @(negedge clk);
    sw_we = 1; sw_idx = idx[3:0]; sw_ready = rdy; sw_wrap = wrp; sw_last = lst; sw_irq = irq;
    sw_len = len[15:0]; sw_addr = adr;
    @(negedge clk);
    sw_we = 0;
  endtask

  task automatic kick(logic [7:0] bits);
    @(negedge clk);
    hclr_we = 1; hclr_data = bits;
    @(negedge clk);
    hclr_we = 0; hclr_data = 0;
  endtask

  task automatic settle();
    for (int k = 0; k < 300; k++) begin
      if (m_mode == 0) break;
      if (m_mode == 2) gstop = 0;
      req_ready = 1;
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    cyc(3);
    #1 chk("R1 reset halted", halted, 1);
    chk("R1 reset req_valid", req_valid, 0);
    chk("R1 reset frame_done", frame_done, 0);
    chk("R1 reset rd_ready", rd_ready, 0);
    @(negedge clk) rst_n = 1;
    cyc(1);
    chk("R1 out of reset halted", halted, 1);

    // one single-entry frame, one two-entry frame, one wrap entry without irq
    wr(2, 1, 0, 1, 1, 64, 32'h1000);
    wr(3, 1, 0, 0, 0, 100, 32'h2000);
    wr(4, 1, 0, 1, 1, 200, 32'h3000);
    wr(5, 1, 1, 1, 0, 60, 32'h4000);
    req_ready = 1;
    kick(8'h40);
    cyc(2);
    chk("R2 other queue bit ignored", halted, 1);
    req_ready = 0;
    kick(8'h80);
    cyc(1);
    #1 chk("R1 first entry at base", req_addr, 32'h1000);
    req_ready = 1;
    cyc(8);
    chk("R7 halted at spent base", halted, 1);
    rd_idx = 3;
    #1 chk("R5 entry returned", rd_ready, 0);

    // backpressure, then halt on a not-ready entry and resume there
    wr(2, 1, 0, 1, 1, 10, 32'h5000);
    req_ready = 0;
    kick(8'h80);
    cyc(4);
    chk("R4 held valid", req_valid, 1);
    chk("R4 held addr", req_addr, 32'h5000);
    req_ready = 1;
    cyc(3);
    chk("R7 halt on not ready", halted, 1);
    wr(3, 1, 0, 1, 1, 20, 32'h6000);
    req_ready = 0;
    kick(8'h80);
    cyc(2);
    chk("R7 resume at same entry", req_addr, 32'h6000);
    req_ready = 1;
    cyc(3);

    // graceful stop raised inside a two-entry frame
    wr(4, 1, 0, 0, 0, 30, 32'h7000);
    wr(5, 1, 1, 1, 1, 40, 32'h8000);
    wr(2, 1, 0, 1, 0, 50, 32'h9000);
    req_ready = 0;
    kick(8'h80);
    cyc(2);
    gstop = 1;
    req_ready = 1;
    cyc(5);
    chk("R9 stopped after frame", stopped, 1);
    chk("R9 no request while stopped", req_valid, 0);
    rd_idx = 5;
    #1 chk("R9 open frame finished", rd_ready, 0);
    gstop = 0;
    req_ready = 0;
    cyc(2);
    chk("R6 base after wrap", req_addr, 32'h9000);
    req_ready = 1;
    settle();

    // randomised rings with random backpressure and stop requests
    for (int it = 0; it < 40; it++) begin
      int b, n;
      settle();
      b = $urandom_range(0, D - 1);
      n = $urandom_range(1, 7);
      base_idx = b[3:0];
      for (int i = 0; i < n; i++)
        wr((b + i) % D, ($urandom_range(0, 9) != 0), (i == n - 1), ($urandom_range(0, 2) == 0) || (i == n - 1),
           $urandom_range(0, 1), $urandom_range(1, 1500), 32'hC000_0000 + it * 256 + i);
      kick(8'h80);
      for (int k = 0; k < 30; k++) begin
        @(negedge clk);
        req_ready = $urandom_range(0, 2) != 0;
        rd_idx = 4'($urandom_range(0, D - 1));
        if ($urandom_range(0, 9) == 0) gstop = !gstop;
      end
      gstop = 0;
    end
    settle();
    cyc(2);
    summary();
    $finish;
  end
endmodule